// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Controller

This block is the interrupt front end for a group of channel sources that share one processor interrupt line with other devices. Each source raises a one-cycle request, and the block keeps that request as a pending flag. The block joins a serial priority chain through an enable input (`iei_i`) and an enable output (`ieo_o`). A device nearer the head of the chain masks every device behind it. Inside the block, a lower channel number means a higher priority.

When a request may be served, the block pulls the active-low interrupt line low. The processor then runs an acknowledge cycle, which it marks by driving the fetch strobe and the I/O strobe low together. In that cycle the block moves the winning channel from pending to in-service and returns a vector made from a software-written base and the channel number. The channel stays in service, and keeps the chain closed, until the block sees the two-byte return-from-interrupt opcode sequence (0xED, then 0x4D) in two fetch cycles that follow each other.

All control inputs are active low and sampled on the rising clock edge. A fetch cycle is a period with `m1_n_i` low and `iorq_n_i` high. The opcode of a fetch is the value `bus_data_i` held on the last clock edge before `m1_n_i` returns high.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, no channel is pending or in service, `base` is 0, `int_n_o` is 1, `vec_oe_o` is 0, and `ieo_o` follows `iei_i`.
- R2: A high `chan_req_i[i]` on a clock edge makes channel i pending. `int_n_o` goes low when a pending channel has `iei_i` high and no lower-numbered channel pending or in service, and no in-service flag of its own.
- R3: While `iei_i` is low, `ieo_o` is low and `int_n_o` is high, whatever the internal state.
- R4: An acknowledge serves the lowest-numbered channel that may interrupt under R2.
- R5: The vector equals base bits 7:3, then the 2-bit channel number in bits 2:1, then 0 in bit 0. It is driven, with `vec_oe_o` high, from the cycle after the first acknowledge edge until `m1_n_i` or `iorq_n_i` rises. At all other times `vec_oe_o` is 0 and `vec_o` is 0.
- R6: An acknowledge moves the served channel from pending to in service. `ieo_o` stays low while any channel is in service, and lower channels cannot interrupt.
- R7: While any channel is pending, `ieo_o` is low whenever `m1_n_i` is low. With `m1_n_i` high, pending channels alone do not hold `ieo_o` low.
- R8: A fetch of 0xED followed at once by a fetch of 0x4D, with `iei_i` high, clears the in-service flag of the lowest-numbered in-service channel. The block is then free to raise `ieo_o` or interrupt again.
- R9: A fetch of 0x4D without 0xED in the fetch just before it releases nothing.
- R10: A return sequence seen while `iei_i` is low releases nothing.
- R11: A channel with a lower number than an in-service channel can still interrupt and be served (nesting). Releases then proceed from the lowest number upward.
- R12: An acknowledge with no channel allowed to interrupt leaves `vec_oe_o` low and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | NCH | One-cycle request pulse per channel |
| base_wr_i | input | 1 | Write strobe for the vector base |
| base_wdata_i | input | 8 | New vector base |
| m1_n_i | input | 1 | Fetch strobe, active low |
| iorq_n_i | input | 1 | I/O strobe, active low; low together with `m1_n_i` marks an acknowledge |
| bus_data_i | input | 8 | Data bus snooped for opcodes |
| iei_i | input | 1 | Chain enable from the higher-priority neighbour |
| ieo_o | output | 1 | Chain enable to the lower-priority neighbour |
| int_n_o | output | 1 | Interrupt request, active low |
| vec_o | output | 8 | Vector returned during an acknowledge |
| vec_oe_o | output | 1 | High while `vec_o` should be driven onto the bus |

## Verification
The hardest state to reach from the ports is nesting. A high-priority channel has to be served while a lower one is already in service, and the two return sequences then have to release them in the right order while a third request waits behind both. The bench builds this in a fixed order: it serves one channel, adds a request that must stay blocked, adds a higher one that must win, and then gives two return sequences. The decoder's reaction to near-miss opcode streams is reached by fetch sequences that split the prefix from the second byte, or that give the second byte alone.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   localparam int OPC_W = 8;
   localparam logic [OPC_W-1:0] RET_PREFIX = 8'hED;
   localparam logic [OPC_W-1:0] RET_SECOND = 8'h4D;

   typedef struct packed {
      logic             ack_start;
      logic             ack_cyc;
      logic             fetch_done;
      logic [OPC_W-1:0] fetch_op;
   } bus_evt_t;
endpackage

// File: rtl/irq_bus_snoop.sv
module irq_bus_snoop
   import irq_chain_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             m1_n_i,
   input  logic             iorq_n_i,
   input  logic [OPC_W-1:0] data_i,
   output bus_evt_t         evt_o
);
   logic             m1_q;
   logic             ack_cyc_q;
   logic [OPC_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_q      <= 1'b1;
         ack_cyc_q <= 1'b0;
         data_q    <= '0;
      end else begin
         m1_q      <= m1_n_i;
         data_q    <= data_i;
         ack_cyc_q <= m1_n_i ? 1'b0 : (ack_cyc_q | ~iorq_n_i);
      end
   end

   always_comb begin
      evt_o.ack_start  = ~m1_n_i & ~iorq_n_i & ~ack_cyc_q;
      evt_o.ack_cyc    = ack_cyc_q;
      evt_o.fetch_done = m1_n_i & ~m1_q & ~ack_cyc_q;
      evt_o.fetch_op   = data_q;
   end

   // R5: an acknowledge starts only once per cycle of the fetch strobe
   a_r5_ack_once: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.ack_start |=> !evt_o.ack_start);
endmodule

// File: rtl/irq_reti_decode.sv
module irq_reti_decode
   import irq_chain_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_evt_t evt_i,
   input  logic     iei_i,
   output logic     rel_o
);
   logic pfx_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pfx_seen_q <= 1'b0;
      else if (evt_i.fetch_done)
         pfx_seen_q <= (evt_i.fetch_op == RET_PREFIX);
   end

   assign rel_o = evt_i.fetch_done & pfx_seen_q & iei_i
                & (evt_i.fetch_op == RET_SECOND);

   // R8: a release happens only on the edge that completes a fetch
   a_r8_release_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      rel_o |-> $past(!evt_i.ack_cyc));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input  logic [NCH-1:0]  ip_i,
   input  logic [NCH-1:0]  ius_i,
   input  logic            iei_i,
   output logic [NCH-1:0]  gnt_o,
   output logic [NCH-1:0]  rel_sel_o,
   output logic            any_gnt_o,
   output logic [CH_W-1:0] gnt_idx_o
);
   logic blocked;

   always_comb begin
      blocked = ~iei_i;
      for (int i = 0; i < NCH; i++) begin
         gnt_o[i] = ip_i[i] & ~blocked & ~ius_i[i];
         blocked  = blocked | ip_i[i] | ius_i[i];
      end
   end

   assign rel_sel_o = ius_i & (~ius_i + NCH'(1));
   assign any_gnt_o = |gnt_o;

   always_comb begin
      gnt_idx_o = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (gnt_o[i]) gnt_idx_o = CH_W'(i);
   end
endmodule

// File: rtl/irq_chan_slot.sv
module irq_chan_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic take_i,
   input  logic rel_i,
   output logic ip_o,
   output logic ius_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip_o  <= 1'b0;
         ius_o <= 1'b0;
      end else begin
         ip_o  <= (ip_o & ~take_i) | req_i;
         ius_o <= (ius_o | take_i) & ~rel_i;
      end
   end

   // R6: a channel is served only out of the pending state
   a_r6_take_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> ip_o);
   // R6: once served, the slot is in service on the next cycle
   a_r6_take_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> ius_o);
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
   import irq_chain_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   chan_req_i,
   input  logic             base_wr_i,
   input  logic [OPC_W-1:0] base_wdata_i,
   input  logic             m1_n_i,
   input  logic             iorq_n_i,
   input  logic [OPC_W-1:0] bus_data_i,
   input  logic             iei_i,
   output logic             ieo_o,
   output logic             int_n_o,
   output logic [OPC_W-1:0] vec_o,
   output logic             vec_oe_o
);
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int BASE_LSB = CH_W + 1;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("irq_chain_ctrl: NCH must be at least 1");
      end
      if (BASE_LSB >= OPC_W) begin : g_bad_width
         $error("irq_chain_ctrl: too many channels for the vector width");
      end
   endgenerate

   bus_evt_t          evt;
   logic              rel;
   logic [NCH-1:0]    ip, ius, gnt, rel_sel;
   logic              any_gnt;
   logic [CH_W-1:0]   gnt_idx;
   logic [OPC_W-1:0]  base_q, vec_q;
   logic              vec_hit_q;

   irq_bus_snoop u_snoop (
      .clk(clk), .rst_n(rst_n), .m1_n_i(m1_n_i), .iorq_n_i(iorq_n_i),
      .data_i(bus_data_i), .evt_o(evt));

   irq_reti_decode u_reti (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .iei_i(iei_i), .rel_o(rel));

   irq_prio_resolve #(.NCH(NCH), .CH_W(CH_W)) u_prio (
      .ip_i(ip), .ius_i(ius), .iei_i(iei_i), .gnt_o(gnt),
      .rel_sel_o(rel_sel), .any_gnt_o(any_gnt), .gnt_idx_o(gnt_idx));

   for (genvar g = 0; g < NCH; g++) begin : g_slot
      irq_chan_slot u_slot (
         .clk(clk), .rst_n(rst_n), .req_i(chan_req_i[g]),
         .take_i(evt.ack_start & gnt[g]), .rel_i(rel & rel_sel[g]),
         .ip_o(ip[g]), .ius_o(ius[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (base_wr_i)
         base_q <= base_wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q     <= '0;
         vec_hit_q <= 1'b0;
      end else if (evt.ack_start) begin
         vec_hit_q <= any_gnt;
         if (any_gnt)
            vec_q <= {base_q[OPC_W-1:BASE_LSB], gnt_idx, 1'b0};
      end else if (m1_n_i) begin
         vec_hit_q <= 1'b0;
      end
   end

   assign ieo_o    = iei_i & ~(|ius) & ~((|ip) & ~m1_n_i);
   assign int_n_o  = ~any_gnt;
   assign vec_oe_o = vec_hit_q & ~m1_n_i & ~iorq_n_i;
   assign vec_o    = vec_oe_o ? vec_q : '0;

   // R3: a closed chain upstream silences the block
   a_r3_chain_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !iei_i |-> (!ieo_o && int_n_o));
   // R5: the vector appears only inside an acknowledge and has bit 0 clear
   a_r5_vec_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> (!m1_n_i && !iorq_n_i && !vec_o[0]));
   // R6: serving a channel closes the chain on the following cycle
   a_r6_chain_held: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.ack_start && any_gnt) |=> !ieo_o);
   // R12: an acknowledge with no winner drives no vector
   a_r12_no_winner: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.ack_start && !any_gnt) |=> !vec_oe_o);
   // R4: at most one channel wins at a time
   a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
endmodule

// File: tb/tb_irq_chain_ctrl.sv
module tb_irq_chain_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] chan_req = '0;
   logic       base_wr = 1'b0;
   logic [7:0] base_wdata = '0;
   logic       m1_n = 1'b1, iorq_n = 1'b1;
   logic [7:0] bus_data = '0;
   logic       iei = 1'b1;
   logic       ieo, int_n, vec_oe;
   logic [7:0] vec;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   logic [7:0] cap_vec;
   logic       cap_oe;

   always #4 clk = ~clk;

   irq_chain_ctrl #(.NCH(4)) dut (
      .clk(clk), .rst_n(rst_n), .chan_req_i(chan_req), .base_wr_i(base_wr),
      .base_wdata_i(base_wdata), .m1_n_i(m1_n), .iorq_n_i(iorq_n),
      .bus_data_i(bus_data), .iei_i(iei), .ieo_o(ieo), .int_n_o(int_n),
      .vec_o(vec), .vec_oe_o(vec_oe));

   typedef struct packed {
      logic [3:0] req;
      logic [7:0] base;
      logic [7:0] exp_vec;
   } vrow_t;

   localparam vrow_t TBL [5] = '{
      '{4'b1111, 8'h00, 8'h00},
      '{4'b1010, 8'hF8, 8'hFA},
      '{4'b1000, 8'h40, 8'h46},
      '{4'b0100, 8'hA9, 8'hAC},
      '{4'b0110, 8'h17, 8'h12}
   };

   task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      iei = 1'b1; m1_n = 1'b1; iorq_n = 1'b1; chan_req = '0;
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_base(input logic [7:0] b);
      @(negedge clk) base_wr = 1'b1; base_wdata = b;
      @(negedge clk) base_wr = 1'b0;
   endtask

   task automatic pulse_req(input logic [3:0] m);
      @(negedge clk) chan_req = m;
      @(negedge clk) chan_req = '0;
      #1;
   endtask

   task automatic do_ack();
      @(negedge clk) m1_n = 1'b0; iorq_n = 1'b0;
      @(negedge clk) #1;
      cap_vec = vec; cap_oe = vec_oe;
      m1_n = 1'b1; iorq_n = 1'b1;
      @(negedge clk) #1;
   endtask

   task automatic fetch(input logic [7:0] op);
      @(negedge clk) m1_n = 1'b0; bus_data = op;
      @(negedge clk) m1_n = 1'b1;
      @(negedge clk) #1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      #1;
      check("R1 int_n", {7'd0, int_n}, 8'd1);
      check("R1 ieo", {7'd0, ieo}, 8'd1);
      check("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
      check("R1 vec", vec, 8'h00);

      // table: R2, R4, R5, R6, R8
      foreach (TBL[k]) begin
         logic [3:0] rem;
         rem = TBL[k].req & (TBL[k].req - 4'd1);
         do_reset();
         write_base(TBL[k].base);
         pulse_req(TBL[k].req);
         check("R2 int_n low", {7'd0, int_n}, 8'd0);
         do_ack();
         check("R4 R5 vector", cap_vec, TBL[k].exp_vec);
         check("R5 vec_oe in ack", {7'd0, cap_oe}, 8'd1);
         check("R5 vec_oe after ack", {7'd0, vec_oe}, 8'd0);
         check("R6 ieo held", {7'd0, ieo}, 8'd0);
         check("R6 int_n released", {7'd0, int_n}, 8'd1);
         fetch(8'hED);
         fetch(8'h4D);
         check("R8 ieo reopened", {7'd0, ieo}, 8'd1);
         check("R8 next request", {7'd0, int_n}, {7'd0, rem == 4'd0});
      end

      // R3 and R12: closed chain
      do_reset();
      pulse_req(4'b0001);
      iei = 1'b0; #1;
      check("R3 ieo", {7'd0, ieo}, 8'd0);
      check("R3 int_n", {7'd0, int_n}, 8'd1);
      do_ack();
      check("R12 no vector", {7'd0, cap_oe}, 8'd0);
      iei = 1'b1; #1;
      check("R12 still pending", {7'd0, int_n}, 8'd0);
      check("R12 not in service", {7'd0, ieo}, 8'd1);

      // R7: pending holds chain only with fetch strobe low
      do_reset();
      pulse_req(4'b1000);
      @(negedge clk) m1_n = 1'b0; #1;
      check("R7 ieo m1 low", {7'd0, ieo}, 8'd0);
      m1_n = 1'b1; #1;
      check("R7 ieo m1 high", {7'd0, ieo}, 8'd1);

      // R9: broken sequences do not release
      do_reset();
      pulse_req(4'b0100);
      do_ack();
      fetch(8'h4D);
      check("R9 lone second byte", {7'd0, ieo}, 8'd0);
      fetch(8'hED); fetch(8'h00); fetch(8'h4D);
      check("R9 split sequence", {7'd0, ieo}, 8'd0);
      fetch(8'hED); fetch(8'h4D);
      check("R9 full sequence", {7'd0, ieo}, 8'd1);

      // R10: sequence with chain closed upstream
      do_reset();
      pulse_req(4'b0010);
      do_ack();
      iei = 1'b0;
      fetch(8'hED); fetch(8'h4D);
      iei = 1'b1; #1;
      check("R10 ignored", {7'd0, ieo}, 8'd0);
      fetch(8'hED); fetch(8'h4D);
      check("R10 later release", {7'd0, ieo}, 8'd1);

      // R11: nesting
      do_reset();
      write_base(8'h80);
      pulse_req(4'b0100);
      do_ack();
      check("R11 first vector", cap_vec, 8'h84);
      pulse_req(4'b1000);
      check("R11 lower blocked", {7'd0, int_n}, 8'd1);
      pulse_req(4'b0001);
      check("R11 higher interrupts", {7'd0, int_n}, 8'd0);
      do_ack();
      check("R11 nested vector", cap_vec, 8'h80);
      fetch(8'hED); fetch(8'h4D);
      check("R11 outer still held", {7'd0, ieo}, 8'd0);
      check("R11 ch3 still blocked", {7'd0, int_n}, 8'd1);
      fetch(8'hED); fetch(8'h4D);
      check("R11 ch3 now free", {7'd0, int_n}, 8'd0);
      do_ack();
      check("R11 ch3 vector", cap_vec, 8'h86);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule